// File: doc/BRIEF.md
# Programmable-Level Peripheral Interrupt Router

This block takes a vector of level-sensitive peripheral interrupt lines and steers each one to one of seven general-purpose priority levels of a processor core. Every peripheral owns a 4-bit level field. The fields are packed eight to a 32-bit register, so software can move any source to any level while the system runs. Each input line is captured into a raw status vector. A line takes part only while its mask bit is also set. The block drives one registered request line per level toward the core.

When the core services a level, its dispatch logic presents that level on a query port. In the same cycle the block returns the lowest-numbered active source routed to that level, together with a valid bit. If no such source exists, the block raises a spurious flag instead and adds one to a saturating spurious counter. A separate wakeup-enable register selects which raw status bits may wake the core. A simple synchronous register port reads and writes the level fields, the mask and the wakeup enables. The same port reads back the raw status and the spurious count.

Top module: `prio_irq_router`

## Requirements
- R1: After reset, all level requests and `wake_o` are low. The mask register, the wakeup register, every level field and the spurious count all read as zero.
- R2: The level field of source n sits in the register at address n/8, bits (n mod 8)*4+3 down to (n mod 8)*4. A field value v from 0 to 6 routes the source to level v, where level 0 is the lowest general-purpose level.
- R3: A field value from 7 to 15 routes the source to no level. Such a source never raises a request and never wins a query.
- R4: A source is active only while both its raw status bit and its mask bit are 1. The input is captured into raw status at one clock edge. `lvl_req_o[v]` is the registered OR of all active sources routed to level v, so it follows an input change by two clocks and a mask write by one further clock.
- R5: While `q_en` is high, `q_valid` goes to 1 and `q_src` gives the lowest-indexed active source routed to level `q_lvl`, both in the same cycle.
- R6: While `q_en` is high and no active source is routed to `q_lvl` (including any `q_lvl` of 7), `q_spur` is 1 and `q_valid` is 0. The spurious count then rises by one at the next clock and saturates at its maximum. Cycles with `q_en` low, or with a valid result, leave the count unchanged.
- R7: A write takes effect at the next clock edge. The register map is: addresses 0 to 3 hold the level fields, 8 the mask (bit n for source n), 9 the wakeup enables, 10 the raw status (read only) and 11 the spurious count (read only). Every other address reads as 0. Writes to read-only or unmapped addresses have no effect.
- R8: `wake_o` is the OR of raw status AND wakeup enables, independent of the mask. A single write of all ones to address 9 enables every source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 32 | Level-sensitive peripheral interrupt lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| lvl_req_o | output | 7 | Registered per-level request to the core |
| q_en | input | 1 | Service query strobe |
| q_lvl | input | 3 | Level being serviced |
| q_valid | output | 1 | Query found an active source |
| q_src | output | 5 | Index of the winning source |
| q_spur | output | 1 | Query found no source |
| wake_o | output | 1 | Wakeup indication |

## Verification
Routing is tried with single sources placed at the edges of the field layout: source 10 in the second register and source 31 in the top nibble of the last register. This shows whether the offset and register selection are right. Several sources sharing one level, with the lowest of them later masked off, tell a correct lowest-index search apart from a highest-index one or from a fixed pick. Field codes 7 and 15, and pending but masked sources, separate "routed nowhere" and "not active" from real requests. Queries on empty levels, on level 7, with the strobe low and with a valid winner separate the cases that must advance the spurious count from those that must not.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int FLD_W       = 4;
    localparam int FLD_PER_REG = 8;
    localparam int REG_W       = 32;
    localparam int ADDR_W      = 4;

    localparam logic [ADDR_W-1:0] ADR_MASK = 4'd8;
    localparam logic [ADDR_W-1:0] ADR_WAKE = 4'd9;
    localparam logic [ADDR_W-1:0] ADR_RAW  = 4'd10;
    localparam logic [ADDR_W-1:0] ADR_SPUR = 4'd11;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  data;
    } reg_wr_t;

    function automatic logic [FLD_W-1:0] slot_field(input logic [REG_W-1:0] r, input int slot);
        return r[slot*FLD_W +: FLD_W];
    endfunction
endpackage

// File: rtl/pirq_regs.sv
module pirq_regs
    import pirq_pkg::*;
#(
    parameter int N_SRC = 32,
    parameter int CNT_W = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  reg_wr_t                       wr,
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic [N_SRC-1:0]              raw,
    input  logic [CNT_W-1:0]              spur_cnt,
    output logic [N_SRC-1:0][FLD_W-1:0]   fld,
    output logic [N_SRC-1:0]              mask_q,
    output logic [N_SRC-1:0]              wake_q,
    output logic [REG_W-1:0]              rd_data
);
    localparam int N_AREG = N_SRC / FLD_PER_REG;

    logic [N_AREG-1:0][REG_W-1:0] areg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            areg_q <= '0;
            mask_q <= '0;
            wake_q <= '0;
        end else if (wr.en) begin
            for (int a = 0; a < N_AREG; a++)
                if (wr.addr == ADDR_W'(a)) areg_q[a] <= wr.data;
            if (wr.addr == ADR_MASK) mask_q <= wr.data[N_SRC-1:0];
            if (wr.addr == ADR_WAKE) wake_q <= wr.data[N_SRC-1:0];
        end
    end

    for (genvar n = 0; n < N_SRC; n++) begin : g_fld
        assign fld[n] = slot_field(areg_q[n / FLD_PER_REG], n % FLD_PER_REG);
    end

    always_comb begin
        rd_data = '0;
        for (int a = 0; a < N_AREG; a++)
            if (rd_addr == ADDR_W'(a)) rd_data = areg_q[a];
        case (rd_addr)
            ADR_MASK: rd_data = REG_W'(mask_q);
            ADR_WAKE: rd_data = REG_W'(wake_q);
            ADR_RAW:  rd_data = REG_W'(raw);
            ADR_SPUR: rd_data = REG_W'(spur_cnt);
            default:  ;
        endcase
    end

    a_r7_mask_write_next: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.addr == ADR_MASK) |=> (mask_q == $past(wr.data[N_SRC-1:0])));
    a_r7_wake_write_next: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.addr == ADR_WAKE) |=> (wake_q == $past(wr.data[N_SRC-1:0])));
endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_pkg::*;
#(
    parameter int N_SRC = 32,
    parameter int N_LVL = 7
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N_SRC-1:0]              active,
    input  logic [N_SRC-1:0][FLD_W-1:0]   fld,
    output logic [N_LVL-1:0][N_SRC-1:0]   hits,
    output logic [N_LVL-1:0]              req_q
);
    for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
        for (genvar n = 0; n < N_SRC; n++) begin : g_src
            assign hits[l][n] = active[n] && (fld[n] == FLD_W'(l));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else for (int l = 0; l < N_LVL; l++) req_q[l] <= |hits[l];
    end
endmodule

// File: rtl/pirq_pick.sv
module pirq_pick #(
    parameter int N_SRC = 32,
    parameter int N_LVL = 7,
    localparam int IDX_W = $clog2(N_SRC),
    localparam int LVL_W = $clog2(N_LVL + 1)
) (
    input  logic [N_LVL-1:0][N_SRC-1:0] hits,
    input  logic                        q_en,
    input  logic [LVL_W-1:0]            q_lvl,
    output logic                        q_valid,
    output logic [IDX_W-1:0]            q_src
);
    logic [N_SRC-1:0] row;

    always_comb begin
        row = '0;
        for (int l = 0; l < N_LVL; l++)
            if (q_lvl == LVL_W'(l)) row = hits[l];
        q_src = '0;
        for (int i = N_SRC - 1; i >= 0; i--)
            if (row[i]) q_src = IDX_W'(i);
        q_valid = q_en && (|row);
    end
endmodule

// File: rtl/prio_irq_router.sv
module prio_irq_router
    import pirq_pkg::*;
#(
    parameter int N_SRC = 32,
    parameter int N_LVL = 7,
    parameter int CNT_W = 16,
    localparam int IDX_W = $clog2(N_SRC),
    localparam int LVL_W = $clog2(N_LVL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  irq_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic [N_LVL-1:0]  lvl_req_o,
    input  logic              q_en,
    input  logic [LVL_W-1:0]  q_lvl,
    output logic              q_valid,
    output logic [IDX_W-1:0]  q_src,
    output logic              q_spur,
    output logic              wake_o
);
    logic [N_SRC-1:0]            raw_q, mask_q, wake_q, active;
    logic [N_SRC-1:0][FLD_W-1:0] fld;
    logic [N_LVL-1:0][N_SRC-1:0] hits;
    logic [CNT_W-1:0]            spur_cnt_q;
    reg_wr_t                     wr;

    assign wr = '{en: wr_en, addr: wr_addr, data: wr_data};

    always_ff @(posedge clk) begin
        if (rst) raw_q <= '0;
        else     raw_q <= irq_i;
    end

    pirq_regs #(.N_SRC(N_SRC), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr(wr), .rd_addr(rd_addr), .raw(raw_q),
        .spur_cnt(spur_cnt_q), .fld(fld), .mask_q(mask_q), .wake_q(wake_q),
        .rd_data(rd_data)
    );

    assign active = raw_q & mask_q;

    pirq_router #(.N_SRC(N_SRC), .N_LVL(N_LVL)) u_router (
        .clk(clk), .rst(rst), .active(active), .fld(fld),
        .hits(hits), .req_q(lvl_req_o)
    );

    pirq_pick #(.N_SRC(N_SRC), .N_LVL(N_LVL)) u_pick (
        .hits(hits), .q_en(q_en), .q_lvl(q_lvl),
        .q_valid(q_valid), .q_src(q_src)
    );

    assign q_spur = q_en && !q_valid;
    assign wake_o = |(raw_q & wake_q);

    always_ff @(posedge clk) begin
        if (rst)                               spur_cnt_q <= '0;
        else if (q_spur && spur_cnt_q != '1)   spur_cnt_q <= spur_cnt_q + 1'b1;
    end

    // Independent candidate vector for the query checks
    logic [N_SRC-1:0] chk_cand;
    always_comb
        for (int n = 0; n < N_SRC; n++)
            chk_cand[n] = raw_q[n] && mask_q[n] && (fld[n] == FLD_W'(q_lvl)) && (int'(q_lvl) < N_LVL);

    a_r4_winner_active: assert property (@(posedge clk) disable iff (rst)
        q_valid |-> chk_cand[q_src]);
    a_r5_winner_lowest: assert property (@(posedge clk) disable iff (rst)
        q_valid |-> ((chk_cand & ((N_SRC'(1) << q_src) - N_SRC'(1))) == '0));
    a_r6_spur_counts: assert property (@(posedge clk) disable iff (rst)
        (q_spur && spur_cnt_q != '1) |=> (spur_cnt_q == $past(spur_cnt_q) + 1'b1));
    a_r6_count_still: assert property (@(posedge clk) disable iff (rst)
        !q_spur |=> $stable(spur_cnt_q));
endmodule

// File: tb/test_prio_irq_router.sv
module test_prio_irq_router;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] irq;
    logic        wr_en;
    logic [3:0]  wr_addr, rd_addr;
    logic [31:0] wr_data, rd_data;
    logic [6:0]  lvl_req_o;
    logic        q_en, q_valid, q_spur, wake_o;
    logic [2:0]  q_lvl;
    logic [4:0]  q_src;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    prio_irq_router i_prio_irq_router (
        .clk(clk), .rst(rst), .irq_i(irq), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .lvl_req_o(lvl_req_o), .q_en(q_en), .q_lvl(q_lvl), .q_valid(q_valid),
        .q_src(q_src), .q_spur(q_spur), .wake_o(wake_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic query(input logic [2:0] l);
        q_en = 1'b1; q_lvl = l; #1;
    endtask

    task automatic do_reset;
        rst = 1'b1; irq = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr = '0; q_en = 1'b0; q_lvl = '0;
        step(2);
        rst = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        do_reset();
        chk("R1 lvl_req", lvl_req_o, 0);
        chk("R1 wake_o", wake_o, 0);
        rd(4'd8, d);  chk("R1 mask", d, 0);
        rd(4'd9, d);  chk("R1 wake reg", d, 0);
        rd(4'd11, d); chk("R1 spur count", d, 0);
        for (int a = 0; a < 4; a++) begin
            rd(4'(a), d); chk("R1 level field reg", d, 0);
        end
    endtask

    task automatic t_fields;
        do_reset();
        wr(4'd1, 32'h0000_0500);              // source 10 -> level 5
        wr(4'd3, 32'h6000_0000);              // source 31 -> level 6
        wr(4'd8, 32'h8000_0400);
        irq = 32'h8000_0400;
        step(2);
        chk("R2 R4 requests at level 5 and 6", lvl_req_o, 7'h60);
        query(3'd5); chk("R2 level5 valid", q_valid, 1); chk("R5 level5 src", q_src, 10);
        query(3'd6); chk("R2 level6 valid", q_valid, 1); chk("R5 level6 src", q_src, 31);
        query(3'd0); chk("R6 level0 empty spur", q_spur, 1);
        q_en = 1'b0;
    endtask

    task automatic t_noroute;
        do_reset();
        wr(4'd0, 32'h000F_7000);              // source 3 -> code 7, source 4 -> code 15
        wr(4'd8, 32'h0000_0018);
        irq = 32'h0000_0018;
        step(2);
        chk("R3 codes 7 and 15 raise nothing", lvl_req_o, 0);
        query(3'd0); chk("R3 no winner at level 0", q_valid, 0);
        q_en = 1'b0;
    endtask

    task automatic t_mask;
        do_reset();
        wr(4'd0, 32'h0000_0030);              // source 1 -> level 3
        irq = 32'h0000_0002;
        step(2);
        chk("R4 masked source no request", lvl_req_o, 0);
        query(3'd3); chk("R4 masked source no winner", q_valid, 0);
        q_en = 1'b0;
        wr(4'd8, 32'h0000_0002);
        query(3'd3); chk("R4 unmasked winner", q_valid, 1);
        q_en = 1'b0;
        step(1);
        chk("R4 request one clock after mask write", lvl_req_o, 7'h08);
        irq = '0;
        step(1);
        chk("R4 request still held one clock", lvl_req_o, 7'h08);
        step(1);
        chk("R4 request drops two clocks after input", lvl_req_o, 0);
    endtask

    task automatic t_lowest;
        do_reset();
        for (int a = 0; a < 4; a++) wr(4'(a), 32'h2222_2222);
        wr(4'd8, 32'hFFFF_FFFF);
        irq = (32'h1 << 20) | (32'h1 << 12) | (32'h1 << 5);
        step(1);
        query(3'd2); chk("R5 lowest of 5,12,20", q_src, 5); chk("R5 valid", q_valid, 1);
        q_en = 1'b0;
        wr(4'd8, 32'hFFFF_FFDF);
        query(3'd2); chk("R5 lowest after masking 5", q_src, 12);
        q_en = 1'b0;
    endtask

    task automatic t_spur;
        logic [31:0] d;
        do_reset();
        query(3'd4); chk("R6 empty level spur", q_spur, 1); chk("R6 empty level valid", q_valid, 0);
        step(1); q_en = 1'b0;
        rd(4'd11, d); chk("R6 count after one spur", d, 1);
        query(3'd7); chk("R6 level 7 spur", q_spur, 1);
        step(1); q_en = 1'b0;
        rd(4'd11, d); chk("R6 count after level 7", d, 2);
        step(3);
        rd(4'd11, d); chk("R6 idle leaves count", d, 2);
        wr(4'd8, 32'h1);
        irq = 32'h1;
        step(1);
        query(3'd0); chk("R6 valid query", q_valid, 1);
        step(1); q_en = 1'b0;
        rd(4'd11, d); chk("R6 valid query leaves count", d, 2);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        do_reset();
        wr(4'd10, 32'hFFFF_FFFF);
        rd(4'd10, d); chk("R7 raw status not writable", d, 0);
        wr(4'd11, 32'h0000_00FF);
        rd(4'd11, d); chk("R7 count not writable", d, 0);
        wr(4'd5, 32'hDEAD_BEEF);
        rd(4'd5, d); chk("R7 unmapped reads zero", d, 0);
        wr(4'd8, 32'hA5A5_A5A5);
        rd(4'd8, d); chk("R7 mask readback", d, 32'hA5A5_A5A5);
        wr(4'd2, 32'h1234_5678);
        rd(4'd2, d); chk("R7 field reg readback", d, 32'h1234_5678);
        irq = 32'h0000_0081;
        step(1);
        rd(4'd10, d); chk("R7 raw follows input", d, 32'h81);
    endtask

    task automatic t_wake;
        logic [31:0] d;
        do_reset();
        irq = 32'h0000_0080;
        step(1);
        chk("R8 no wake while disabled", wake_o, 0);
        wr(4'd9, 32'hFFFF_FFFF);
        chk("R8 wake with mask clear", wake_o, 1);
        rd(4'd9, d); chk("R8 all enabled in one write", d, 32'hFFFF_FFFF);
        irq = '0;
        step(1);
        chk("R8 wake drops with input", wake_o, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_fields();
                t_noroute();
                t_mask();
                t_lowest();
                t_spur();
                t_regs();
                t_wake();
            end
            begin
                #1_000_000;
                checks++; errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule